// File: doc/BRIEF.md
# Configurable 16-pin GPIO Port Controller

This block controls a group of general-purpose pins from a simple register bus. For each pin it decides one of three things: the pin is an input, the pin drives both levels, or the pin only pulls low and releases the pad for a high. It sends an output value and an output enable to each pad cell. It takes the pad levels back in through a synchronizer, so software reads the real pin state and not what it last wrote.

A separate mask marks each pin as digital or analog. After reset every pin is analog. An analog pin's input path is forced low before the synchronizer, so a PORT read shows zero for that pin whatever the pad level. The mask does not change the output drive, which still follows direction, open-drain and latch.

The bus does one access per cycle. Writes are a plain store or a single-cycle bit set, clear or toggle. On the PORT address, the bit operations take the sampled pin levels as their starting value, not the latch. Because the pad input passes through register stages, a PORT read in the cycle just after a write or a direction change still shows the old pad state.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, DIR (address 0) reads 0xFFFF, and LAT (address 2), ODC (address 3) and DIGEN (address 4) read 0x0000. `pad_oe` is all zeros.
- R2: A pin whose DIR bit is 1 has its `pad_oe` bit at 0.
- R3: A pin with DIR bit 0 and ODC bit 0 has its `pad_oe` bit at 1, and its `pad_out` bit equals its LAT bit.
- R4: A pin with DIR bit 0 and ODC bit 1 releases the pad (`pad_oe` 0) when its LAT bit is 1. It drives low (`pad_oe` 1, `pad_out` 0) when its LAT bit is 0.
- R5: A PORT (address 1) read returns the pad level through a two-stage synchronizer. A level present before clock edge N is visible after edge N+1, and not after edge N alone.
- R6: A pin whose DIGEN bit is 0 (analog) reads 0 at PORT, whatever its pad level.
- R7: A plain write to PORT stores the data in the output latch, and LAT reads return the latch unchanged.
- R8: The write operation is selected by `bus_op`: 0 store, 1 set the bits that are 1 in the data, 2 clear them, 3 toggle them. On the PORT address the starting value is the PORT read value (the pins). On every other address it is the register itself.
- R9: A PORT read in the cycle right after a latch write that changes a driven pin returns the old pin level. The new level appears two cycles later.
- R10: Addresses 5 to 7 read 0, and writes to them change no register.
- R11: The DIGEN mask does not affect `pad_oe` or `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_op | input | 2 | Write operation: store, set, clear or toggle |
| bus_wdata | input | 16 | Write data or bit mask |
| bus_rdata | output | 16 | Read data for `bus_addr`, same cycle |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enables |

## Verification
The bench loops `pad_out` and `pad_oe` back onto `pad_in`, and an external level fills in wherever a pad is released. This lets it test the same latch pattern in three configurations: push-pull, open-drain and input. Comparing the pad lines across these three shows that each mode is decoded correctly.

A bit set on PORT with inputs held at a pattern different from the latch tells pin-based from latch-based read-modify-write. Reading PORT one cycle and then three cycles after a latch write tells a registered input path from a transparent one. With the pads held high while the pins are analog, the PORT read must be zero even though the pins are driven, which shows that the mask gates the input and leaves the output drive alone.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        ADR_DIR   = 3'd0,
        ADR_PORT  = 3'd1,
        ADR_LAT   = 3'd2,
        ADR_ODC   = 3'd3,
        ADR_DIGEN = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_STORE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } wr_op_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   bus_addr,
    input  logic         bus_we,
    input  logic [1:0]   bus_op,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] pin_rd,
    output logic [W-1:0] bus_rdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] odc_q,
    output logic [W-1:0] digen_q
);
    logic [W-1:0] base_val;
    logic [W-1:0] next_val;

    always_comb begin
        case (reg_addr_e'(bus_addr))
            ADR_DIR:   base_val = dir_q;
            ADR_PORT:  base_val = pin_rd;
            ADR_LAT:   base_val = lat_q;
            ADR_ODC:   base_val = odc_q;
            ADR_DIGEN: base_val = digen_q;
            default:   base_val = '0;
        endcase
    end

    assign bus_rdata = base_val;

    always_comb begin
        unique case (wr_op_e'(bus_op))
            OP_STORE:  next_val = bus_wdata;
            OP_SET:    next_val = base_val | bus_wdata;
            OP_CLEAR:  next_val = base_val & ~bus_wdata;
            OP_TOGGLE: next_val = base_val ^ bus_wdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '1;
            lat_q   <= '0;
            odc_q   <= '0;
            digen_q <= '0;
        end else if (bus_we) begin
            case (reg_addr_e'(bus_addr))
                ADR_DIR:              dir_q   <= next_val;
                ADR_PORT, ADR_LAT:    lat_q   <= next_val;
                ADR_ODC:              odc_q   <= next_val;
                ADR_DIGEN:            digen_q <= next_val;
                default: ;
            endcase
        end
    end

    AST_PORT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_PORT && bus_op == OP_STORE) |=> (lat_q == $past(bus_wdata))); // R7
    AST_PORT_SET_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_PORT && bus_op == OP_SET) |=> (lat_q == ($past(pin_rd) | $past(bus_wdata)))); // R8
    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr > 3'd4) |=> ($stable(dir_q) && $stable(lat_q) && $stable(odc_q) && $stable(digen_q))); // R10
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] digen,
    output logic [W-1:0] pin_level
);
    logic [W-1:0] gated;
    logic [W-1:0] stg [STAGES];

    assign gated = pad_in & digen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= gated;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign pin_level = stg[STAGES-1] & digen;

    AST_FIRST_STAGE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stg[0] == $past(gated))); // R5
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] odc_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (dir_q[i]) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
            end else if (odc_q[i]) begin
                pad_oe[i]  = ~lat_q[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = lat_q[i];
            end
        end
    end

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & dir_q) == '0)); // R2
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & odc_q) == '0)); // R4
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int PIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_we,
    input  logic [1:0]       bus_op,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe
);
    logic [PIN_W-1:0] dir_q, lat_q, odc_q, digen_q, pin_rd;

    gpio_regs #(.W(PIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_op(bus_op), .bus_wdata(bus_wdata), .pin_rd(pin_rd),
        .bus_rdata(bus_rdata), .dir_q(dir_q), .lat_q(lat_q),
        .odc_q(odc_q), .digen_q(digen_q)
    );

    gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .digen(digen_q),
        .pin_level(pin_rd)
    );

    gpio_pad_ctrl #(.W(PIN_W)) u_pad (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .lat_q(lat_q),
        .odc_q(odc_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_PORT) |-> ((bus_rdata & ~digen_q) == '0)); // R6
    AST_PUSH_PULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | dir_q | odc_q) == '1)); // R3
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [1:0]  bus_op = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata, pad_out, pad_oe, pad_in;
    logic [15:0] ext_lvl = 16'h0000;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_op = op; bus_wdata = d; bus_we = 1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 0; bus_op = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R1 DIR", v, 16'hFFFF);
        rd(3'd2, v); check("R1 LAT", v, 16'h0000);
        rd(3'd3, v); check("R1 ODC", v, 16'h0000);
        rd(3'd4, v); check("R1 DIGEN", v, 16'h0000);
        check("R1 pad_oe", pad_oe, 16'h0000);
    endtask

    task automatic t_analog_zero();
        logic [15:0] v;
        ext_lvl = 16'hFFFF;
        settle();
        rd(3'd1, v); check("R6 analog PORT", v, 16'h0000);
    endtask

    task automatic t_input_sync();
        logic [15:0] v;
        wr(3'd4, 2'd0, 16'hFFFF);
        ext_lvl = 16'h1234;
        settle();
        rd(3'd1, v); check("R5 steady input", v, 16'h1234);
        ext_lvl = 16'h00F0;
        @(posedge clk); @(negedge clk);
        rd(3'd1, v); check("R5 one edge old", v, 16'h1234);
        @(posedge clk); @(negedge clk);
        rd(3'd1, v); check("R5 two edges new", v, 16'h00F0);
    endtask

    task automatic t_push_pull();
        logic [15:0] v;
        wr(3'd0, 2'd0, 16'h0000);
        wr(3'd1, 2'd0, 16'h5A5A);
        check("R3 pad_oe", pad_oe, 16'hFFFF);
        check("R3 pad_out", pad_out, 16'h5A5A);
        rd(3'd2, v); check("R7 LAT read", v, 16'h5A5A);
    endtask

    task automatic t_open_drain();
        wr(3'd3, 2'd0, 16'h00FF);
        check("R4 pad_oe", pad_oe, 16'hFFA5);
        check("R4 pad_out", pad_out, 16'h5A00);
    endtask

    task automatic t_dir_input();
        wr(3'd3, 2'd0, 16'h0000);
        wr(3'd0, 2'd0, 16'h0F0F);
        check("R2 pad_oe", pad_oe, 16'hF0F0);
    endtask

    task automatic t_read_after_write();
        logic [15:0] v;
        wr(3'd0, 2'd0, 16'h0000);
        wr(3'd1, 2'd0, 16'h0000);
        settle();
        wr(3'd1, 2'd0, 16'h00FF);
        rd(3'd1, v); check("R9 next cycle old", v, 16'h0000);
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd1, v); check("R9 later new", v, 16'h00FF);
    endtask

    task automatic t_rmw();
        logic [15:0] v;
        wr(3'd0, 2'd0, 16'hFF00);
        wr(3'd1, 2'd0, 16'h0000);
        ext_lvl = 16'hA500;
        settle();
        wr(3'd1, 2'd1, 16'h0001);
        rd(3'd2, v); check("R8 PORT set uses pins", v, 16'hA501);
        wr(3'd2, 2'd3, 16'h00FF);
        rd(3'd2, v); check("R8 LAT toggle", v, 16'hA5FE);
        wr(3'd0, 2'd2, 16'h0F00);
        rd(3'd0, v); check("R8 DIR clear", v, 16'hF000);
    endtask

    task automatic t_analog_output();
        logic [15:0] v;
        wr(3'd4, 2'd0, 16'h0000);
        wr(3'd0, 2'd0, 16'h0000);
        wr(3'd2, 2'd0, 16'h8001);
        settle();
        check("R11 pad_oe", pad_oe, 16'hFFFF);
        check("R11 pad_out", pad_out, 16'h8001);
        rd(3'd1, v); check("R6 driven analog PORT", v, 16'h0000);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr(3'd5, 2'd0, 16'h1111);
        rd(3'd5, v); check("R10 read unmapped", v, 16'h0000);
        rd(3'd0, v); check("R10 DIR kept", v, 16'h0000);
        rd(3'd2, v); check("R10 LAT kept", v, 16'h8001);
        wr(3'd7, 2'd1, 16'hFFFF);
        rd(3'd4, v); check("R10 DIGEN kept", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_analog_zero();
        t_input_sync();
        t_push_pull();
        t_open_drain();
        t_dir_input();
        t_read_after_write();
        t_rmw();
        t_analog_output();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule